// File: doc/BRIEF.md
# Eight-Decade BCD Counter with Output Latches

This block counts falling edges of an external pulse in decimal. It has eight cascaded BCD decades and runs entirely in the system clock domain. Every control input is sampled through a two-flop synchronizer. A falling-edge detector turns each count, test-count and overflow edge into a one-cycle enable. A separate test-count input enters the chain at the third decade, so the upper digits can be exercised without thousands of base-rate pulses.

A sticky overflow flip-flop is set by its own input. While the active-low load strobe is held, the counter value and the overflow flip-flop are copied into a set of output latches. Between strobes the latches hold, so a downstream display or reader sees a coherent value that does not move. The most significant bits of the top three decades are brought out unlatched, so one of them can be wired back to the overflow input. The active-low counter clear empties the decades and the overflow flip-flop together.

Top module: `dec8_counter_latch`

## Requirements
- R1: Each falling edge of `cnt_in` adds one to the counter. The value is BCD, with digit k (k=0 least significant) at bits 4k+3:4k, and every digit stays in 0..9. Rising edges and steady levels change nothing.
- R2: From the all-nines value, one more count gives all zeros.
- R3: While `clr_n` is low, all decades and the overflow flip-flop are cleared. A count edge that arrives in the same cycle as the clear is discarded.
- R4: A falling edge of `ovf_in` sets the overflow flip-flop. It stays set through later edges until a clear.
- R5: While `ld_n` is low, `bcd_q` takes the counter value and `ovf_q` takes the overflow flip-flop. While `ld_n` is high, both outputs hold their last loaded value.
- R6: Each falling edge of `tst_in` adds one at digit index TEST_DIGIT (default 2, bits 11:8) and carries upward. Digits below that index are untouched.
- R7: When count and test-count edges fall in the same cycle, both increments take effect.
- R8: `msb_top` bit 0, 1 and 2 are the live, unlatched MSBs of decades DIGITS-2, DIGITS-1 and DIGITS (decades 6, 7 and 8 by default).
- R9: With `rst_n` low, the counter, the latches and the overflow flip-flop are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| cnt_in | input | 1 | Count pulse; falling edge increments |
| tst_in | input | 1 | Test-count pulse; falling edge increments from digit TEST_DIGIT |
| ovf_in | input | 1 | Overflow source; falling edge sets the overflow flip-flop |
| clr_n | input | 1 | Counter and overflow clear, active low |
| ld_n | input | 1 | Load strobe, active low; latches follow counter while low |
| bcd_q | output | 4*DIGITS | Latched BCD value |
| msb_top | output | 3 | Unlatched MSBs of the three highest decades |
| ovf_q | output | 1 | Latched overflow flag |

## Verification
Two collisions matter. The first is the counter clear against a count edge. The bench drops `cnt_in` and `clr_n` on the same clock edge and holds the clear for exactly one period. Because both pass through equal synchronizer depth, the clear and the count enable reach the counter in the same cycle, and a later load must show zero. The second is count against test-count. Several table rows toggle both inputs together, and the latched result must equal the sum of both increments.

// File: rtl/dec8_counter_latch.sv
module dec8_counter_latch #(
  parameter int DIGITS      = 8,
  parameter int TEST_DIGIT  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cnt_in,
  input  logic                  tst_in,
  input  logic                  ovf_in,
  input  logic                  clr_n,
  input  logic                  ld_n,
  output logic [4*DIGITS-1:0]   bcd_q,
  output logic [2:0]            msb_top,
  output logic                  ovf_q
);
  localparam int W   = 4 * DIGITS;
  localparam int NIN = 5;
  localparam logic [NIN-1:0] IDLE = 5'b11000;

  logic [NIN-1:0] raw, cur;
  logic [NIN-1:0] stage [SYNC_STAGES];
  logic [2:0]     last;
  logic           cnt_fe, tst_fe, ovf_fe, clr_low, ld_low;
  logic [W-1:0]   cnt_q, step1, cnt_d;
  logic           ovf_ff;

  function automatic logic [W-1:0] bump(input logic [W-1:0] v, input int from);
    logic [W-1:0] r;
    logic c;
    r = v;
    c = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (i >= from && c) begin
        if (r[4*i +: 4] == 4'd9) r[4*i +: 4] = 4'd0;
        else begin
          r[4*i +: 4] = r[4*i +: 4] + 4'd1;
          c = 1'b0;
        end
      end
    end
    return r;
  endfunction

  function automatic logic digits_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  assign raw = {ld_n, clr_n, ovf_in, tst_in, cnt_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stage[s] <= IDLE;
      last <= IDLE[2:0];
    end else begin
      stage[0] <= raw;
      for (int s = 1; s < SYNC_STAGES; s++) stage[s] <= stage[s-1];
      last <= cur[2:0];
    end
  end

  assign cur     = stage[SYNC_STAGES-1];
  assign cnt_fe  = last[0] & ~cur[0];
  assign tst_fe  = last[1] & ~cur[1];
  assign ovf_fe  = last[2] & ~cur[2];
  assign clr_low = ~cur[3];
  assign ld_low  = ~cur[4];

  assign step1 = cnt_fe ? bump(cnt_q, 0) : cnt_q;
  assign cnt_d = tst_fe ? bump(step1, TEST_DIGIT) : step1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_low) cnt_q <= '0;
    else              cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_ff <= 1'b0;
    else if (clr_low) ovf_ff <= 1'b0;
    else if (ovf_fe)  ovf_ff <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcd_q <= '0;
      ovf_q <= 1'b0;
    end else if (ld_low) begin
      bcd_q <= cnt_q;
      ovf_q <= ovf_ff;
    end
  end

  assign msb_top = {cnt_q[W-1], cnt_q[W-5], cnt_q[W-9]};

  AST_BCD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) digits_ok(cnt_q)); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!clr_low && !cnt_fe && !tst_fe) |=> $stable(cnt_q)); // R1
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n) clr_low |=> (cnt_q == '0) && !ovf_ff); // R3
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n) (!clr_low && ovf_fe) |=> ovf_ff); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (!clr_low && ovf_ff) |=> ovf_ff); // R4
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n) ld_low |=> (bcd_q == $past(cnt_q)) && (ovf_q == $past(ovf_ff))); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ld_low |=> $stable(bcd_q) && $stable(ovf_q)); // R5
  AST_LOW_DIGITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (!clr_low && !cnt_fe && tst_fe) |=> cnt_q[4*TEST_DIGIT-1:0] == $past(cnt_q[4*TEST_DIGIT-1:0])); // R6
endmodule

// File: tb/dec8_counter_latch_tb.sv
`timescale 1ns/1ps
module dec8_counter_latch_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cnt_in, tst_in, ovf_in, clr_n, ld_n;
  logic [31:0] bcd_q;
  logic [15:0] sm_bcd;
  logic [2:0]  msb_top, sm_msb;
  logic        ovf_q, sm_ovf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  dec8_counter_latch u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .tst_in(tst_in), .ovf_in(ovf_in),
    .clr_n(clr_n), .ld_n(ld_n), .bcd_q(bcd_q), .msb_top(msb_top), .ovf_q(ovf_q));

  dec8_counter_latch #(.DIGITS(4), .TEST_DIGIT(2)) u_small (
    .clk(clk), .rst_n(rst_n), .cnt_in(cnt_in), .tst_in(tst_in), .ovf_in(ovf_in),
    .clr_n(clr_n), .ld_n(ld_n), .bcd_q(sm_bcd), .msb_top(sm_msb), .ovf_q(sm_ovf));

  typedef struct packed {
    logic [15:0] nc;
    logic [15:0] nt;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{16'd1,  16'd0, 32'h00000001},
    '{16'd8,  16'd0, 32'h00000009},
    '{16'd1,  16'd0, 32'h00000010},
    '{16'd90, 16'd0, 32'h00000100},
    '{16'd0,  16'd5, 32'h00000600},
    '{16'd99, 16'd0, 32'h00000699},
    '{16'd1,  16'd0, 32'h00000700},
    '{16'd3,  16'd4, 32'h00001103}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(input int nc, input int nt);
    int n;
    n = (nc > nt) ? nc : nt;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      cnt_in = (k < nc) ? 1'b0 : 1'b1;
      tst_in = (k < nt) ? 1'b0 : 1'b1;
      @(negedge clk);
      cnt_in = 1'b1;
      tst_in = 1'b1;
    end
    idle(6);
  endtask

  task automatic do_load();
    @(negedge clk) ld_n = 1'b0;
    idle(2);
    ld_n = 1'b1;
    idle(6);
  endtask

  task automatic do_clear();
    @(negedge clk) clr_n = 1'b0;
    idle(3);
    clr_n = 1'b1;
    idle(6);
  endtask

  task automatic ovf_pulse();
    @(negedge clk) ovf_in = 1'b0;
    idle(2);
    ovf_in = 1'b1;
    idle(6);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cnt_in = 1'b1; tst_in = 1'b1; ovf_in = 1'b1; clr_n = 1'b1; ld_n = 1'b1;
    idle(5);
    check("R9 bcd after reset", bcd_q, 32'h0);
    check("R9 ovf after reset", {31'd0, ovf_q}, 32'h0);
    check("R9 msb after reset", {29'd0, msb_top}, 32'h0);
    rst_n = 1'b1;
    idle(4);

    pulses(99, 99);
    do_load();
    check("R6 R7 small all nines", {16'd0, sm_bcd}, 32'h00009999);
    check("R8 small top msbs", {29'd0, sm_msb}, 32'h7);
    pulses(1, 0);
    do_load();
    check("R2 small rollover", {16'd0, sm_bcd}, 32'h0);
    check("R8 small msbs after wrap", {29'd0, sm_msb}, 32'h0);

    do_clear();
    do_load();
    check("R3 clear", bcd_q, 32'h0);

    for (int i = 0; i < 8; i++) begin
      pulses(int'(VECS[i].nc), int'(VECS[i].nt));
      do_load();
      check("R1 R6 R7 vector", bcd_q, VECS[i].exp);
    end

    // R3: clear and count edge reach the counter in the same cycle
    @(negedge clk);
    cnt_in = 1'b0;
    clr_n  = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    idle(3);
    cnt_in = 1'b1;
    idle(6);
    do_load();
    check("R3 clear beats count", bcd_q, 32'h0);
    pulses(2, 0);
    do_load();
    check("R1 counting after clear", bcd_q, 32'h00000002);

    ovf_pulse();
    check("R5 ovf latch holds before load", {31'd0, ovf_q}, 32'h0);
    do_load();
    check("R4 ovf set", {31'd0, ovf_q}, 32'h1);
    ovf_pulse();
    do_load();
    check("R4 ovf stays set", {31'd0, ovf_q}, 32'h1);
    do_clear();
    check("R5 ovf held across clear", {31'd0, ovf_q}, 32'h1);
    check("R5 bcd held across clear", bcd_q, 32'h00000002);
    do_load();
    check("R3 ovf cleared", {31'd0, ovf_q}, 32'h0);
    check("R3 bcd cleared", bcd_q, 32'h0);

    pulses(0, 7000);
    check("R8 msbs at 00700000", {29'd0, msb_top}, 32'h0);
    check("R5 bcd held without load", bcd_q, 32'h0);
    pulses(0, 1000);
    check("R8 decade 6 msb live", {29'd0, msb_top}, 32'h1);
    do_load();
    check("R6 test count reach", bcd_q, 32'h00800000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule